// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution unit of a simple scalar core. Each cycle in which `op_valid` is high, it takes two 32-bit operands and an opcode. It runs one of the following operations: add, subtract, increment, decrement, bitwise AND, OR and XOR, bitwise invert, negate, a logical shift left or right, or a compare. On the next clock edge it registers the result, a write-enable for the destination register, and a condition-flags word.

The flags word holds carry, zero, sign and overflow at fixed bit positions. A separate condition evaluator reads the registered flags together with a condition code, and drives a branch-taken bit with no extra latency. This lets the instruction after a compare decide a conditional jump.

The shift amount comes from an 8-bit immediate or from the low byte of a count register. Only its low five bits are used.

Top module: `int_alu_core`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `result_we` and `flags` become all zeros.
- R2: A valid add, subtract, increment or decrement writes A+B, A-B, A+1 or A-1 (modulo 2^32) to `result` with `result_we` high, one cycle after the operation. Opcodes: add 0, sub 1, inc 2, dec 3.
- R3: A valid AND (4), OR (5), XOR (6), NOT (7) or NEG (8) writes A&B, A|B, A^B, ~A or 0-A, with `result_we` high one cycle later.
- R4: Shift left (9) and shift right (10) move A by the count and fill the vacated bits with zeros. The count is `shamt_imm[4:0]` when `shamt_sel` is 0, and `shamt_reg[4:0]` when it is 1, so any count above 31 is taken modulo 32.
- R5: A shift whose masked count is zero writes A unchanged and leaves all flags unchanged.
- R6: Every flag-updating operation sets zero flag `flags[6]` when its 32-bit result is zero, and sets sign flag `flags[7]` to the result's bit 31. The flag-updating operations are all except NOT and reserved opcodes.
- R7: Carry `flags[0]`: for add it is the carry out; for sub and compare it is the borrow (A<B unsigned); for negate it is A!=0; for a shift it is the last bit shifted out; for logic ops it is 0; for inc and dec it is kept. Overflow `flags[11]` is signed overflow for add, sub, compare, inc, dec and negate, and is 0 for logic ops and shifts.
- R8: Compare (11) sets the flags exactly as subtract would, keeps `result_we` low, and leaves `result` unchanged.
- R9: NOT leaves all flags unchanged. Reserved opcodes 12 to 15 change neither `result` nor `flags`, and keep `result_we` low.
- R10: A cycle with `op_valid` low leaves `result` and `flags` unchanged and drives `result_we` low at the next edge.
- R11: `branch_taken` is a combinational function of `cond_code` and the registered flags (Z zero, S sign, V overflow): 0 equal (Z), 1 not equal (!Z), 2 zero (Z), 3 greater (!Z and S==V), 4 greater-or-equal (S==V), 5 less (S!=V), 6 less-or-equal (Z or S!=V), 7 always.
- R12: Flag bits other than 0, 6, 7 and 11 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand; also the shifted value |
| opnd_b | input | 32 | Second operand |
| shamt_sel | input | 1 | Shift count source: 0 immediate, 1 count register |
| shamt_imm | input | 8 | Immediate shift count |
| shamt_reg | input | 32 | Count register; low byte supplies the count |
| cond_code | input | 3 | Branch condition select |
| result | output | 32 | Registered result |
| result_we | output | 1 | Registered destination write enable |
| flags | output | 32 | Registered condition-flags word |
| branch_taken | output | 1 | Condition holds on the registered flags |

## Verification
The bench aims at the arithmetic boundaries. These are 0x7FFFFFFF+1, 0xFFFFFFFF+1, negating 0x80000000 and 0, and decrementing 0x80000000. A wrong carry or overflow rule there flips `flags[0]` or `flags[11]`, and through them the signed branch conditions. Shift counts of 32, 33 and 31 from both sources expose a design that does not mask the count: it would produce zero, or update the flags where the value should pass through untouched. A compare of equal operands, with a distinct value already in `result`, catches a design that writes the difference or loses the zero flag. Reserved opcodes, NOT and idle cycles catch flags that change when they must hold.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
    localparam int DW      = 32;
    localparam int SHW     = $clog2(DW);
    localparam int CF_POS  = 0;
    localparam int ZF_POS  = 6;
    localparam int SF_POS  = 7;
    localparam int OF_POS  = 11;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_NEG = 4'd8,
        OP_SHL = 4'd9,
        OP_SHR = 4'd10,
        OP_CMP = 4'd11
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_EQ  = 3'd0,
        CC_NE  = 3'd1,
        CC_ZR  = 3'd2,
        CC_GT  = 3'd3,
        CC_GE  = 3'd4,
        CC_LT  = 3'd5,
        CC_LE  = 3'd6,
        CC_ALW = 3'd7
    } cond_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
    } flag_set_t;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          write;
        flag_set_t     flg;
    } alu_out_t;

    function automatic logic [DW-1:0] pack_flags(input flag_set_t f);
        logic [DW-1:0] w;
        w         = '0;
        w[CF_POS] = f.cf;
        w[ZF_POS] = f.zf;
        w[SF_POS] = f.sf;
        w[OF_POS] = f.of;
        return w;
    endfunction
endpackage

// File: rtl/alu_exec.sv
`timescale 1ns/1ps
module alu_exec
    import alu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [SHW-1:0]   shamt,
    input  flag_set_t        flags_in,
    output alu_out_t         out
);
    localparam int MSB = DW - 1;

    logic [DW:0]   wide;
    logic [DW-1:0] r;
    logic          upd;

    always_comb begin
        wide      = '0;
        r         = a;
        upd       = 1'b0;
        out.write = 1'b0;
        out.flg   = flags_in;
        case (op)
            OP_ADD: begin
                wide       = {1'b0, a} + {1'b0, b};
                r          = wide[DW-1:0];
                out.write  = 1'b1;
                upd        = 1'b1;
                out.flg.cf = wide[DW];
                out.flg.of = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
            end
            OP_SUB, OP_CMP: begin
                wide       = {1'b0, a} - {1'b0, b};
                r          = wide[DW-1:0];
                out.write  = (op == OP_SUB);
                upd        = 1'b1;
                out.flg.cf = wide[DW];
                out.flg.of = (a[MSB] != b[MSB]) && (r[MSB] != a[MSB]);
            end
            OP_INC: begin
                r          = a + 1'b1;
                out.write  = 1'b1;
                upd        = 1'b1;
                out.flg.of = r[MSB] & ~a[MSB];
            end
            OP_DEC: begin
                r          = a - 1'b1;
                out.write  = 1'b1;
                upd        = 1'b1;
                out.flg.of = a[MSB] & ~r[MSB];
            end
            OP_AND, OP_OR, OP_XOR: begin
                r          = (op == OP_AND) ? (a & b) :
                             (op == OP_OR)  ? (a | b) : (a ^ b);
                out.write  = 1'b1;
                upd        = 1'b1;
                out.flg.cf = 1'b0;
                out.flg.of = 1'b0;
            end
            OP_NOT: begin
                r         = ~a;
                out.write = 1'b1;
            end
            OP_NEG: begin
                r          = '0 - a;
                out.write  = 1'b1;
                upd        = 1'b1;
                out.flg.cf = (a != '0);
                out.flg.of = a[MSB] & r[MSB];
            end
            OP_SHL: begin
                out.write = 1'b1;
                if (shamt != '0) begin
                    wide       = {1'b0, a} << shamt;
                    r          = wide[DW-1:0];
                    upd        = 1'b1;
                    out.flg.cf = wide[DW];
                    out.flg.of = 1'b0;
                end
            end
            OP_SHR: begin
                out.write = 1'b1;
                if (shamt != '0) begin
                    wide       = {a, 1'b0} >> shamt;
                    r          = wide[DW:1];
                    upd        = 1'b1;
                    out.flg.cf = wide[0];
                    out.flg.of = 1'b0;
                end
            end
            default: begin
                r = a;
            end
        endcase
        if (upd) begin
            out.flg.zf = (r == '0);
            out.flg.sf = r[MSB];
        end
        out.value = r;
    end
endmodule

// File: rtl/alu_state_reg.sv
`timescale 1ns/1ps
module alu_state_reg
    import alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  alu_out_t      nxt,
    output logic [DW-1:0] result_q,
    output logic          we_q,
    output flag_set_t     flg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            we_q     <= 1'b0;
            flg_q    <= '0;
        end else begin
            we_q <= op_valid & nxt.write;
            if (op_valid) begin
                flg_q <= nxt.flg;
                if (nxt.write) begin
                    result_q <= nxt.value;
                end
            end
        end
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!we_q && $stable(flg_q) && $stable(result_q)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!we_q && result_q == '0 && flg_q == '0));
endmodule

// File: rtl/alu_cond_eval.sv
`timescale 1ns/1ps
module alu_cond_eval
    import alu_pkg::*;
(
    input  cond_e     cc,
    input  flag_set_t f,
    output logic      taken
);
    logic sv_equal;

    always_comb begin
        sv_equal = (f.sf == f.of);
        case (cc)
            CC_EQ, CC_ZR: taken = f.zf;
            CC_NE:        taken = ~f.zf;
            CC_GT:        taken = ~f.zf & sv_equal;
            CC_GE:        taken = sv_equal;
            CC_LT:        taken = ~sv_equal;
            CC_LE:        taken = f.zf | ~sv_equal;
            default:      taken = 1'b1;
        endcase
    end

    // R11
    gt_excludes_le_chk: assert final (!(cc == CC_GT && taken && f.zf));
endmodule

// File: rtl/int_alu_core.sv
`timescale 1ns/1ps
module int_alu_core
    import alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [31:0]   opnd_a,
    input  logic [31:0]   opnd_b,
    input  logic          shamt_sel,
    input  logic [7:0]    shamt_imm,
    input  logic [31:0]   shamt_reg,
    input  logic [2:0]    cond_code,
    output logic [31:0]   result,
    output logic          result_we,
    output logic [31:0]   flags,
    output logic          branch_taken
);
    alu_op_e        op;
    logic [SHW-1:0] shamt;
    flag_set_t      flg_q;
    alu_out_t       nxt;

    assign op    = alu_op_e'(op_code);
    assign shamt = shamt_sel ? shamt_reg[SHW-1:0] : shamt_imm[SHW-1:0];

    alu_exec u_exec (
        .op       (op),
        .a        (opnd_a),
        .b        (opnd_b),
        .shamt    (shamt),
        .flags_in (flg_q),
        .out      (nxt)
    );

    alu_state_reg u_state (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .nxt      (nxt),
        .result_q (result),
        .we_q     (result_we),
        .flg_q    (flg_q)
    );

    alu_cond_eval u_cond (
        .cc    (cond_e'(cond_code)),
        .f     (flg_q),
        .taken (branch_taken)
    );

    assign flags = pack_flags(flg_q);

    // R12
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flags & ~((32'd1 << CF_POS) | (32'd1 << ZF_POS) |
                   (32'd1 << SF_POS) | (32'd1 << OF_POS))) == 32'd0);

    // R8
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd11) |=> (!result_we && $stable(result)));

    // R6
    cmp_equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd11 && opnd_a == opnd_b) |=> flags[6]);

    // R5
    zero_shift_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 4'd9 || op_code == 4'd10) &&
         (shamt_sel ? shamt_reg[4:0] : shamt_imm[4:0]) == 5'd0)
        |=> ($stable(flags) && result == $past(opnd_a)));

    // R9
    reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 4'd12) |=> (!result_we && $stable(flags) && $stable(result)));
endmodule

// File: tb/test_int_alu_core.sv
`timescale 1ns/1ps
module test_int_alu_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [31:0] opnd_a, opnd_b;
    logic        shamt_sel;
    logic [7:0]  shamt_imm;
    logic [31:0] shamt_reg;
    logic [2:0]  cond_code;
    logic [31:0] result;
    logic        result_we;
    logic [31:0] flags;
    logic        branch_taken;

    int checks = 0;
    int errors = 0;

    logic [31:0] e_res;
    logic        e_we, e_c, e_z, e_s, e_v;

    always #2.5 clk = ~clk;

    int_alu_core i_int_alu_core (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt_sel(shamt_sel),
        .shamt_imm(shamt_imm), .shamt_reg(shamt_reg), .cond_code(cond_code),
        .result(result), .result_we(result_we), .flags(flags),
        .branch_taken(branch_taken)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_flags();
        return {20'b0, e_v, 3'b0, e_s, e_z, 5'b0, e_c};
    endfunction

    function automatic logic exp_branch(input int cc);
        case (cc)
            0, 2:    return e_z;
            1:       return !e_z;
            3:       return !e_z && (e_s == e_v);
            4:       return e_s == e_v;
            5:       return e_s != e_v;
            6:       return e_z || (e_s != e_v);
            default: return 1'b1;
        endcase
    endfunction

    // Reference model built from the requirements R2..R9
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input int cnt);
        logic [31:0] r;
        logic        nz;
        r  = a;
        nz = 1'b1;
        e_we = 1'b1;
        case (op)
            4'd0: begin r = a + b; e_c = (33'(a) + 33'(b)) > 33'hFFFFFFFF;
                        e_v = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd1, 4'd11: begin r = a - b; e_c = a < b;
                        e_v = (a[31] != b[31]) && (r[31] != a[31]);
                        e_we = (op == 4'd1); end
            4'd2: begin r = a + 1; e_v = (a == 32'h7FFFFFFF); end
            4'd3: begin r = a - 1; e_v = (a == 32'h80000000); end
            4'd4: begin r = a & b; e_c = 0; e_v = 0; end
            4'd5: begin r = a | b; e_c = 0; e_v = 0; end
            4'd6: begin r = a ^ b; e_c = 0; e_v = 0; end
            4'd7: begin r = ~a; nz = 0; end
            4'd8: begin r = -a; e_c = (a != 0); e_v = (a == 32'h80000000); end
            4'd9: if (cnt == 0) nz = 0;
                  else begin r = a << cnt; e_c = a[32-cnt]; e_v = 0; end
            4'd10: if (cnt == 0) nz = 0;
                  else begin r = a >> cnt; e_c = a[cnt-1]; e_v = 0; end
            default: begin nz = 0; e_we = 0; end
        endcase
        if (nz) begin e_z = (r == 0); e_s = r[31]; end
        if (e_we) e_res = r;
    endtask

    task automatic check_branches(input string tag);
        for (int cc = 0; cc < 8; cc++) begin
            cond_code = 3'(cc);
            #0.2;
            chk($sformatf("R11 %s cc=%0d", tag, cc), {31'b0, branch_taken}, {31'b0, exp_branch(cc)});
        end
    endtask

    task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic sel, input logic [7:0] imm,
                          input logic [31:0] creg);
        @(negedge clk);
        op_valid = 1; op_code = op; opnd_a = a; opnd_b = b;
        shamt_sel = sel; shamt_imm = imm; shamt_reg = creg;
        model(op, a, b, sel ? int'(creg[4:0]) : int'(imm[4:0]));
        @(negedge clk);
        op_valid = 0;
        chk({tag, " result"}, result, e_res);
        chk({tag, " result_we"}, {31'b0, result_we}, {31'b0, e_we});
        chk({tag, " flags"}, flags, exp_flags());
        check_branches(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb, rc;
        logic [3:0]  rop;
        process::self().srandom(32'd2024);
        rst = 1; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
        shamt_sel = 0; shamt_imm = 0; shamt_reg = 0; cond_code = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        e_res = 0; e_we = 0; e_c = 0; e_z = 0; e_s = 0; e_v = 0;
        chk("R1 reset result", result, 0);
        chk("R1 reset result_we", {31'b0, result_we}, 0);
        chk("R1 reset flags", flags, 0);
        check_branches("R1 reset");

        run_op("R2 R7 add signed overflow", 4'd0, 32'h7FFFFFFF, 32'd1, 0, 0, 0);
        run_op("R2 R6 R7 add carry to zero", 4'd0, 32'hFFFFFFFF, 32'd1, 0, 0, 0);
        run_op("R2 R7 sub borrow", 4'd1, 32'd3, 32'd5, 0, 0, 0);
        run_op("R2 R7 inc max", 4'd2, 32'h7FFFFFFF, 0, 0, 0, 0);
        run_op("R2 R7 dec min", 4'd3, 32'h80000000, 0, 0, 0, 0);
        run_op("R3 and", 4'd4, 32'hF0F0_1234, 32'h0000_000F, 0, 0, 0);
        run_op("R8 cmp equal", 4'd11, 32'd77, 32'd77, 0, 0, 0);
        run_op("R8 R11 cmp less signed", 4'd11, 32'hFFFFFFF0, 32'd4, 0, 0, 0);
        run_op("R8 cmp greater", 4'd11, 32'd9, 32'hFFFFFF00, 0, 0, 0);
        run_op("R3 R7 neg zero", 4'd8, 0, 0, 0, 0, 0);
        run_op("R3 R7 neg min", 4'd8, 32'h80000000, 0, 0, 0, 0);
        run_op("R9 not keeps flags", 4'd7, 32'h0000FFFF, 0, 0, 0, 0);
        run_op("R4 shl reg count 33", 4'd9, 32'h8000_0003, 0, 1, 8'd0, 32'h0000_0021);
        run_op("R4 R7 shl imm 31", 4'd9, 32'h0000_0003, 0, 0, 8'd31, 0);
        run_op("R5 shr imm 32 passes", 4'd10, 32'hDEAD_BEEF, 0, 0, 8'd32, 0);
        run_op("R5 shl reg count 0", 4'd9, 32'h1234_5678, 0, 1, 8'd5, 32'h0000_0040);
        run_op("R4 shr imm 1", 4'd10, 32'h0000_0001, 0, 0, 8'd1, 0);
        run_op("R9 reserved op", 4'd13, 32'h5555_5555, 32'h1, 0, 0, 0);

        // R10: idle cycle with busy inputs
        @(negedge clk);
        op_valid = 0; op_code = 4'd0; opnd_a = 32'hFFFFFFFF; opnd_b = 32'h1;
        e_we = 0;
        @(negedge clk);
        chk("R10 idle result", result, e_res);
        chk("R10 idle result_we", {31'b0, result_we}, 0);
        chk("R10 idle flags", flags, exp_flags());

        for (int i = 0; i < 400; i++) begin
            ra = $urandom; rb = $urandom; rc = $urandom;
            case ($urandom % 6)
                0: ra = 32'h7FFFFFFF;
                1: ra = 32'h80000000;
                2: rb = ra;
                3: ra = 0;
                default: ;
            endcase
            rop = 4'($urandom % 16);
            run_op("R2 R3 R4 R6 R7 R12 random", rop, ra, rb, 1'($urandom), 8'($urandom), rc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule